// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block drives the serial clocks of a two-channel audio link in which the controller owns the timing and the codec follows. It divides a fast system clock down to a bit clock and then divides the bit clock further. The second stage gives two left/right frame-sync outputs, one for the transmit path and one for the receive path. Both follow the common two-channel serial format with normal polarity: the frame sync is low for the left word and high for the right word, and it moves only when the bit clock falls.

Software picks a sample rate by pulsing a load strobe with a two-bit rate code and a direction flag. An internal table turns the code into a bit-clock divisor, which both paths share, and a frame period. The period is written only to the divider of the chosen direction. A code outside the table raises a registered error flag and changes nothing. While the block runs, an accepted setting waits for the end of the current transmit frame. This means no half-frame is ever cut short. While the block is disabled, the setting is committed at once, all outputs stay low and every counter is cleared.

Top module: `audclk_gen`

## Requirements
- R1: The bit clock output is high for exactly DIV system-clock cycles and low for exactly DIV cycles, giving a period of 2*DIV.
- R2: Each half-frame of a frame-sync output lasts PERIOD+1 bit-clock periods, that is (PERIOD+1)*2*DIV system cycles. After enable, every frame starts with the low (left) half.
- R3: A frame-sync output changes only in the cycle in which the bit clock falls, while the block stays enabled.
- R4: Rate code 0 selects DIV=25 and PERIOD=74; code 1 selects DIV=7 and PERIOD=66; code 2 selects DIV=13 and PERIOD=23.
- R5: A load with rate code 3 sets rate_err_o in the next cycle and leaves the divisor and both periods unchanged.
- R6: A load with a supported code clears rate_err_o in the next cycle; without a load, rate_err_o holds its value.
- R7: The direction flag routes the period: 0 loads the transmit frame divider, 1 loads the receive frame divider. The other divider keeps its period, and the bit-clock divisor is always updated.
- R8: While enabled, an accepted setting takes effect only at the end of the transmit frame's high half. At that point both frame syncs restart with a low half under the new setting.
- R9: When en_i is low, the bit clock and both frame syncs are low from the next cycle on, and all counters restart, so a re-enabled frame begins with a full low half.
- R10: After reset, all outputs are low and both directions hold the code-0 setting (DIV=25, PERIOD=74).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds outputs low and clears counters |
| cfg_load_i | input | 1 | One-cycle strobe that requests a new rate |
| cfg_rate_i | input | 2 | Rate code: 0, 1, 2 supported, 3 rejected |
| cfg_capture_i | input | 1 | Direction of the request: 0 transmit, 1 receive |
| bclk_o | output | 1 | Bit clock |
| tx_lrclk_o | output | 1 | Transmit frame sync, low = left |
| rx_lrclk_o | output | 1 | Receive frame sync, low = left |
| rate_err_o | output | 1 | Registered flag for a rejected rate code |

## Verification
The assertions check, on every cycle, that the outputs go quiet the cycle after a disable, that a frame sync moves only together with a falling bit clock, and that the error flag is set, cleared and held as the load strobe dictates. Exact widths of bit-clock and half-frame pulses for each table entry, the independence of the two frame dividers, and the rejection of a bad code leaving the previous timing intact are shown only by the bench's measured scenarios. So is the deferral of a mid-frame update to the transmit frame end, which the bench sees as one old-length high half followed by new-length ones.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int DIV_W = 8;
  localparam int PER_W = 8;

  typedef enum logic [1:0] {
    RATE_8K  = 2'd0,
    RATE_32K = 2'd1,
    RATE_48K = 2'd2,
    RATE_BAD = 2'd3
  } rate_e;

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
  } rate_cfg_t;

  function automatic rate_cfg_t rate_lookup(input logic [1:0] code);
    rate_cfg_t c;
    c = '0;
    case (rate_e'(code))
      RATE_8K:  begin c.ok = 1'b1; c.div = DIV_W'(25); c.per = PER_W'(74); end
      RATE_32K: begin c.ok = 1'b1; c.div = DIV_W'(7);  c.per = PER_W'(66); end
      RATE_48K: begin c.ok = 1'b1; c.div = DIV_W'(13); c.per = PER_W'(23); end
      default:  c.ok = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/audclk_bclk_div.sv
module audclk_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i - 1'b1);
  assign fall_o = wrap & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/audclk_frame_div.sv
module audclk_frame_div #(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  output logic             lr_o,
  output logic             end_o
);
  logic [PER_W-1:0] cnt_q;
  logic             lr_q;
  logic             last;

  assign last  = (cnt_q == per_i);
  assign end_o = tick_i & last & lr_q;
  assign lr_o  = lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else if (tick_i) begin
      if (last) begin
        cnt_q <= '0;
        lr_q  <= ~lr_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audclk_cfg.sv
module audclk_cfg
  import audclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [1:0]       rate_i,
  input  logic             capture_i,
  input  logic             frame_end_i,
  output logic [DIV_W-1:0] div_o,
  output logic [PER_W-1:0] tx_per_o,
  output logic [PER_W-1:0] rx_per_o,
  output logic             err_o,
  output logic             commit_o
);
  localparam rate_cfg_t RST_CFG = rate_lookup(2'd0);

  rate_cfg_t        req;
  logic [DIV_W-1:0] pend_div_q;
  logic [PER_W-1:0] pend_per_q;
  logic             pend_cap_q;
  logic             pend_vld_q;

  assign req      = rate_lookup(rate_i);
  // disabled: commit at once; running: wait for transmit frame end
  assign commit_o = pend_vld_q & (frame_end_i | ~en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o      <= RST_CFG.div;
      tx_per_o   <= RST_CFG.per;
      rx_per_o   <= RST_CFG.per;
      err_o      <= 1'b0;
      pend_div_q <= '0;
      pend_per_q <= '0;
      pend_cap_q <= 1'b0;
      pend_vld_q <= 1'b0;
    end else begin
      if (commit_o) begin
        div_o      <= pend_div_q;
        pend_vld_q <= 1'b0;
        if (pend_cap_q) rx_per_o <= pend_per_q;
        else            tx_per_o <= pend_per_q;
      end
      if (load_i) begin
        err_o <= ~req.ok;
        if (req.ok) begin
          pend_div_q <= req.div;
          pend_per_q <= req.per;
          pend_cap_q <= capture_i;
          pend_vld_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cfg_load_i,
  input  logic [1:0] cfg_rate_i,
  input  logic       cfg_capture_i,
  output logic       bclk_o,
  output logic       tx_lrclk_o,
  output logic       rx_lrclk_o,
  output logic       rate_err_o
);
  localparam int N_DIR = 2;  // 0 transmit, 1 receive

  logic [DIV_W-1:0] div;
  logic [PER_W-1:0] per [N_DIR];
  logic [N_DIR-1:0] lr;
  logic [N_DIR-1:0] fend;
  logic             fall;
  logic             commit;
  logic             restart;

  assign restart = ~en_i | commit;

  audclk_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .load_i      (cfg_load_i),
    .rate_i      (cfg_rate_i),
    .capture_i   (cfg_capture_i),
    .frame_end_i (fend[0]),
    .div_o       (div),
    .tx_per_o    (per[0]),
    .rx_per_o    (per[1]),
    .err_o       (rate_err_o),
    .commit_o    (commit)
  );

  audclk_bclk_div #(.DIV_W(DIV_W)) i_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .div_i  (div),
    .bclk_o (bclk_o),
    .fall_o (fall)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : gen_dir
    audclk_frame_div #(.PER_W(PER_W)) i_frame (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (restart),
      .tick_i (fall),
      .per_i  (per[d]),
      .lr_o   (lr[d]),
      .end_o  (fend[d])
    );
  end

  assign tx_lrclk_o = lr[0];
  assign rx_lrclk_o = lr[1];
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       cfg_load_i,
  input logic [1:0] cfg_rate_i,
  input logic       bclk_o,
  input logic       tx_lrclk_o,
  input logic       rx_lrclk_o,
  input logic       rate_err_o
);
  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !tx_lrclk_o && !rx_lrclk_o));

  p_tx_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(tx_lrclk_o)) |-> $fell(bclk_o));

  p_rx_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(rx_lrclk_o)) |-> $fell(bclk_o));

  p_err_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_i && cfg_rate_i == 2'd3) |=> rate_err_o);

  p_err_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_i && cfg_rate_i != 2'd3) |=> !rate_err_o);

  p_err_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(rate_err_o));
endmodule

bind audclk_gen audclk_gen_chk i_audclk_gen_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cfg_load_i (cfg_load_i),
  .cfg_rate_i (cfg_rate_i),
  .bclk_o     (bclk_o),
  .tx_lrclk_o (tx_lrclk_o),
  .rx_lrclk_o (rx_lrclk_o),
  .rate_err_o (rate_err_o)
);

// File: tb/test_audclk_gen.sv
module test_audclk_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       cfg_load_i = 1'b0;
  logic [1:0] cfg_rate_i = 2'd0;
  logic       cfg_capture_i = 1'b0;
  logic       bclk_o, tx_lrclk_o, rx_lrclk_o, rate_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  audclk_gen i_audclk_gen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .cfg_load_i    (cfg_load_i),
    .cfg_rate_i    (cfg_rate_i),
    .cfg_capture_i (cfg_capture_i),
    .bclk_o        (bclk_o),
    .tx_lrclk_o    (tx_lrclk_o),
    .rx_lrclk_o    (rx_lrclk_o),
    .rate_err_o    (rate_err_o)
  );

  // vectors: code, direction, expected err, bclk half, tx half, rx half
  localparam int NV = 4;
  localparam int V_CODE [NV] = '{0, 2, 1, 3};
  localparam int V_CAP  [NV] = '{0, 1, 0, 1};
  localparam int V_ERR  [NV] = '{0, 0, 0, 1};
  localparam int V_BCK  [NV] = '{25, 13, 7, 7};
  localparam int V_TX   [NV] = '{3750, 1950, 938, 938};
  localparam int V_RX   [NV] = '{3750, 624, 336, 336};

  function automatic logic sig(input int s);
    case (s)
      0:       return bclk_o;
      1:       return tx_lrclk_o;
      default: return rx_lrclk_o;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas_high(input int s, output int len);
    int guard = 0;
    len = 0;
    while (sig(s) !== 1'b0 && guard < 20000) begin @(negedge clk_i); guard++; end
    while (sig(s) !== 1'b1 && guard < 20000) begin @(negedge clk_i); guard++; end
    while (sig(s) === 1'b1 && guard < 20000) begin @(negedge clk_i); len++; guard++; end
  endtask

  task automatic load(input int code, input int cap);
    cfg_rate_i    = 2'(code);
    cfg_capture_i = cap[0];
    cfg_load_i    = 1'b1;
    @(negedge clk_i);
    cfg_load_i    = 1'b0;
  endtask

  task automatic cycles_to_tx_rise(output int n);
    n = 0;
    while (tx_lrclk_o !== 1'b1 && n < 20000) begin @(negedge clk_i); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len;
    int n;
    int bad;
    repeat (3) @(negedge clk_i);
    // R10: outputs low during reset
    check("R10 reset outputs", {bclk_o, tx_lrclk_o, rx_lrclk_o, rate_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    en_i = 1'b1;
    cycles_to_tx_rise(n);
    check("R10 R2 default left half", n, 3750);
    check("R10 rx in step", rx_lrclk_o, 1);
    meas_high(0, len);
    check("R10 R1 default bclk high", len, 25);

    for (int v = 0; v < NV; v++) begin
      en_i = 1'b0;
      @(negedge clk_i);
      load(V_CODE[v], V_CAP[v]);
      check($sformatf("R5 R6 err vec%0d", v), rate_err_o, V_ERR[v]);
      repeat (2) @(negedge clk_i);
      en_i = 1'b1;
      meas_high(0, len);
      check($sformatf("R1 R4 bclk vec%0d", v), len, V_BCK[v]);
      meas_high(1, len);
      check($sformatf("R2 R7 tx half vec%0d", v), len, V_TX[v]);
      meas_high(2, len);
      check($sformatf("R2 R7 rx half vec%0d", v), len, V_RX[v]);
    end

    // R8: update requested mid-frame waits for the transmit frame end
    meas_high(1, len);
    load(0, 0);
    check("R6 err cleared by good load", rate_err_o, 0);
    meas_high(1, len);
    check("R8 current half kept", len, 938);
    meas_high(1, len);
    check("R8 new half applied", len, 3750);
    meas_high(0, len);
    check("R8 R4 new bclk", len, 25);

    // R9: disable forces low and restarts counters
    en_i = 1'b0;
    @(negedge clk_i);
    check("R9 low after disable", {bclk_o, tx_lrclk_o, rx_lrclk_o}, 0);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_i);
      if (bclk_o || tx_lrclk_o || rx_lrclk_o) bad++;
    end
    check("R9 stay low", bad, 0);
    en_i = 1'b1;
    cycles_to_tx_rise(n);
    check("R9 R2 full left half after enable", n, 3750);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule